// File: doc/BRIEF.md
# Conditional Data-Processing Unit with Flag Logic

This block is the combinational execute stage of a 32-bit integer datapath. In one evaluation it decides whether an instruction runs under its 4-bit condition field and the current N, Z, C, V flags. It computes the result of a move, add/subtract (with or without carry, forward or reversed), bitwise, compare or low-word multiply operation. It then reports whether the destination register should be written and what the next flag set is.

The operand shifter sits upstream. It supplies the second operand together with its carry-out and a bit that says whether a shift actually took place. Register reads and writes, and any transfer of the status word into the program counter, belong to the surrounding pipeline. Every input and output is a plain level. There is no state and no handshake, so a result is valid in the same cycle as its operands.

Top module: `cond_alu`

## Requirements
- R1: With opcode encoding ADD=4, ADC=5, SUB=2, SBC=6, RSB=3, RSC=7, the result is rn+op2, rn+op2+C, rn-op2, rn-op2-(1-C), op2-rn and op2-rn-(1-C) respectively, modulo 2^32.
- R2: When these arithmetic operations run with set_flags=1, nzcv_out takes the following values. N is result bit 31. Z is set when the result is zero. C is the adder carry-out, which for subtraction means NOT borrow, so equal operands give C=1 and Z=1. V is signed overflow of the addition as performed. The flag bus packs N into bit 3, Z into bit 2, C into bit 1 and V into bit 0.
- R3: With encoding AND=0, EOR=1, ORR=12, MOV=13, BIC=14, MVN=15, the result is rn&op2, rn^op2, rn|op2, op2, rn&~op2 and ~op2.
- R4: For bitwise and move operations with flags set, N and Z follow the result. C becomes shift_c when shift_used=1 and keeps its old value otherwise. V always keeps its old value.
- R5: The compare opcodes TST=8, TEQ=9, CMP=10 and CMN=11 evaluate rn&op2, rn^op2, rn-op2 and rn+op2. They never assert wr_en, and they update the flags even when set_flags=0. CMP and CMN use the arithmetic flag rules; TST and TEQ use the bitwise rules.
- R6: MUL=16 returns the low 32 bits of rn*op2, and MLA=17 adds acc to that product. With flags set, N and Z follow the result while C and V keep their old values.
- R7: Any non-compare opcode with set_flags=0 leaves nzcv_out equal to nzcv_in while still writing its result.
- R8: cond_pass decodes cond as follows: 0 Z, 1 !Z, 2 C, 3 !C, 4 N, 5 !N, 6 V, 7 !V, 8 C&!Z, 9 !C|Z, 10 N==V, 11 N!=V, 12 !Z&(N==V), 13 Z|(N!=V), 14 always, 15 never.
- R9: When cond_pass=0, wr_en is 0 and nzcv_out equals nzcv_in, whatever the opcode or set_flags.
- R10: Opcodes 18 to 31 are undefined. They give wr_en=0 and nzcv_out=nzcv_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op | input | 5 | Operation code (encodings in R1, R3, R5, R6) |
| rn | input | 32 | First operand |
| op2 | input | 32 | Second operand from the shifter |
| acc | input | 32 | Accumulate addend for MLA |
| shift_c | input | 1 | Shifter carry-out |
| shift_used | input | 1 | Shifter performed a shift |
| set_flags | input | 1 | Flag update requested |
| nzcv_in | input | 4 | Current flags {N,Z,C,V} |
| cond | input | 4 | Condition field |
| result | output | 32 | Operation result |
| wr_en | output | 1 | Destination write enable |
| nzcv_out | output | 4 | Next flags {N,Z,C,V} |
| cond_pass | output | 1 | Condition satisfied |

## Verification
The hardest cases to reach are those where the incoming carry alone decides the outcome. One is SBC or RSC at a signed boundary, where C=0 turns a clean subtract into a borrow and a signed overflow. Another is a bitwise operation whose carry must come from the shifter in one case and be kept in the other. The flags are an input port, so the stimulus presets nzcv_in directly to each such state. It then drives operand pairs at 0x80000000, 0x7FFFFFFF, zero and all-ones. The full 16-by-16 grid of condition codes against flag states is swept to cover the decode.

// File: rtl/calu_pkg.sv
`timescale 1ns/1ps
package calu_pkg;
  localparam int OPW = 5;

  typedef enum logic [OPW-1:0] {
    OP_AND = 5'd0,  OP_EOR = 5'd1,  OP_SUB = 5'd2,  OP_RSB = 5'd3,
    OP_ADD = 5'd4,  OP_ADC = 5'd5,  OP_SBC = 5'd6,  OP_RSC = 5'd7,
    OP_TST = 5'd8,  OP_TEQ = 5'd9,  OP_CMP = 5'd10, OP_CMN = 5'd11,
    OP_ORR = 5'd12, OP_MOV = 5'd13, OP_BIC = 5'd14, OP_MVN = 5'd15,
    OP_MUL = 5'd16, OP_MLA = 5'd17
  } op_e;

  typedef enum logic [1:0] {
    CLS_ARITH = 2'd0,
    CLS_LOGIC = 2'd1,
    CLS_MUL   = 2'd2,
    CLS_NONE  = 2'd3
  } cls_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;
endpackage

// File: rtl/calu_cond.sv
`timescale 1ns/1ps
module calu_cond
  import calu_pkg::*;
(
  input  logic [3:0] cond,
  input  flags_t     fl,
  output logic       pass
);
  logic sgn_eq;
  logic base;

  assign sgn_eq = (fl.n == fl.v);

  // cond[3:1] picks a test, cond[0] inverts it for codes 0..13
  always_comb begin
    unique case (cond[3:1])
      3'd0:    base = fl.z;
      3'd1:    base = fl.c;
      3'd2:    base = fl.n;
      3'd3:    base = fl.v;
      3'd4:    base = fl.c & ~fl.z;
      3'd5:    base = sgn_eq;
      3'd6:    base = ~fl.z & sgn_eq;
      default: base = 1'b1;
    endcase
  end

  assign pass = (cond == 4'd15) ? 1'b0 :
                (cond == 4'd14) ? 1'b1 : (base ^ cond[0]);

  always_comb begin
    // R8
    always_code_chk: assert (!(cond == 4'd14) || pass)
      else $error("always code did not pass");
    // R8
    never_code_chk: assert (!(cond == 4'd15) || !pass)
      else $error("never code passed");
  end
endmodule

// File: rtl/calu_adder.sv
`timescale 1ns/1ps
module calu_adder
  import calu_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [OPW-1:0] op,
  input  logic [DW-1:0]  rn,
  input  logic [DW-1:0]  op2,
  input  logic           c_in,
  output logic [DW-1:0]  sum,
  output logic           c_out,
  output logic           v_out
);
  localparam int MSB = DW - 1;

  logic [DW-1:0] a, b;
  logic          ci;
  logic [DW:0]   wide;

  always_comb begin
    a  = rn;
    b  = op2;
    ci = 1'b0;
    case (op)
      OP_ADD, OP_CMN: ci = 1'b0;
      OP_ADC:         ci = c_in;
      OP_SUB, OP_CMP: begin b = ~op2; ci = 1'b1; end
      OP_SBC:         begin b = ~op2; ci = c_in; end
      OP_RSB:         begin a = op2; b = ~rn; ci = 1'b1; end
      OP_RSC:         begin a = op2; b = ~rn; ci = c_in; end
      default:        ci = 1'b0;
    endcase
  end

  assign wide  = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, ci};
  assign sum   = wide[DW-1:0];
  assign c_out = wide[DW];
  assign v_out = (a[MSB] == b[MSB]) && (sum[MSB] != a[MSB]);
endmodule

// File: rtl/calu_logic.sv
`timescale 1ns/1ps
module calu_logic
  import calu_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [OPW-1:0] op,
  input  logic [DW-1:0]  rn,
  input  logic [DW-1:0]  op2,
  output logic [DW-1:0]  res
);
  always_comb begin
    case (op)
      OP_AND, OP_TST: res = rn & op2;
      OP_EOR, OP_TEQ: res = rn ^ op2;
      OP_ORR:         res = rn | op2;
      OP_MOV:         res = op2;
      OP_BIC:         res = rn & ~op2;
      OP_MVN:         res = ~op2;
      default:        res = '0;
    endcase
  end
endmodule

// File: rtl/calu_mul.sv
`timescale 1ns/1ps
module calu_mul
  import calu_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [OPW-1:0] op,
  input  logic [DW-1:0]  rn,
  input  logic [DW-1:0]  op2,
  input  logic [DW-1:0]  acc,
  output logic [DW-1:0]  res
);
  logic [DW-1:0] prod;
  logic [DW-1:0] addend;

  assign prod   = rn * op2;
  assign addend = (op == OP_MLA) ? acc : '0;
  assign res    = prod + addend;
endmodule

// File: rtl/cond_alu.sv
`timescale 1ns/1ps
module cond_alu
  import calu_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [OPW-1:0] op,
  input  logic [DW-1:0]  rn,
  input  logic [DW-1:0]  op2,
  input  logic [DW-1:0]  acc,
  input  logic           shift_c,
  input  logic           shift_used,
  input  logic           set_flags,
  input  logic [3:0]     nzcv_in,
  input  logic [3:0]     cond,
  output logic [DW-1:0]  result,
  output logic           wr_en,
  output logic [3:0]     nzcv_out,
  output logic           cond_pass
);
  localparam int MSB = DW - 1;

  flags_t        fl_in, fl_new;
  cls_e          cls;
  logic          is_cmp;
  logic          upd;
  logic [DW-1:0] add_res, log_res, mul_res;
  logic          add_c, add_v;

  assign fl_in = flags_t'(nzcv_in);

  calu_cond u_cond (
    .cond (cond),
    .fl   (fl_in),
    .pass (cond_pass)
  );

  calu_adder #(.DW(DW)) u_add (
    .op    (op),
    .rn    (rn),
    .op2   (op2),
    .c_in  (fl_in.c),
    .sum   (add_res),
    .c_out (add_c),
    .v_out (add_v)
  );

  calu_logic #(.DW(DW)) u_log (
    .op  (op),
    .rn  (rn),
    .op2 (op2),
    .res (log_res)
  );

  calu_mul #(.DW(DW)) u_mul (
    .op  (op),
    .rn  (rn),
    .op2 (op2),
    .acc (acc),
    .res (mul_res)
  );

  // operation class decode
  always_comb begin
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_RSB, OP_RSC,
      OP_CMP, OP_CMN:                      cls = CLS_ARITH;
      OP_AND, OP_EOR, OP_ORR, OP_MOV, OP_BIC, OP_MVN,
      OP_TST, OP_TEQ:                      cls = CLS_LOGIC;
      OP_MUL, OP_MLA:                      cls = CLS_MUL;
      default:                             cls = CLS_NONE;
    endcase
  end

  assign is_cmp = (op == OP_TST) || (op == OP_TEQ) ||
                  (op == OP_CMP) || (op == OP_CMN);

  always_comb begin
    unique case (cls)
      CLS_ARITH: result = add_res;
      CLS_LOGIC: result = log_res;
      CLS_MUL:   result = mul_res;
      default:   result = '0;
    endcase
  end

  always_comb begin
    fl_new.n = result[MSB];
    fl_new.z = (result == '0);
    fl_new.c = fl_in.c;
    fl_new.v = fl_in.v;
    if (cls == CLS_ARITH) begin
      fl_new.c = add_c;
      fl_new.v = add_v;
    end else if (cls == CLS_LOGIC && shift_used) begin
      fl_new.c = shift_c;
    end
  end

  assign wr_en    = cond_pass && (cls != CLS_NONE) && !is_cmp;
  assign upd      = cond_pass && (cls != CLS_NONE) && (set_flags || is_cmp);
  assign nzcv_out = upd ? fl_new : nzcv_in;

  always_comb begin
    // R9
    fail_quiet_chk: assert (cond_pass || (!wr_en && nzcv_out == nzcv_in))
      else $error("failed condition still acted");
    // R5
    cmp_no_write_chk: assert (!(op >= OP_TST && op <= OP_CMN) || !wr_en)
      else $error("compare wrote a result");
    // R4
    logic_v_keep_chk: assert (cls != CLS_LOGIC || nzcv_out[0] == nzcv_in[0])
      else $error("bitwise op changed V");
    // R6
    mul_cv_keep_chk: assert (cls != CLS_MUL || nzcv_out[1:0] == nzcv_in[1:0])
      else $error("multiply changed C or V");
    // R7
    no_set_keep_chk: assert (set_flags || is_cmp || nzcv_out == nzcv_in)
      else $error("flags moved without request");
    // R10
    undef_quiet_chk: assert (op <= OP_MLA || (!wr_en && nzcv_out == nzcv_in))
      else $error("undefined opcode acted");
  end
endmodule

// File: tb/cond_alu_tb_top.sv
`timescale 1ns/1ps
module cond_alu_tb_top;
  logic        clk = 1'b0;
  logic [4:0]  op;
  logic [31:0] rn, op2, acc;
  logic        shift_c, shift_used, set_flags;
  logic [3:0]  nzcv_in, cond;
  logic [31:0] result;
  logic        wr_en;
  logic [3:0]  nzcv_out;
  logic        cond_pass;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  cond_alu dut_i (
    .op(op), .rn(rn), .op2(op2), .acc(acc),
    .shift_c(shift_c), .shift_used(shift_used), .set_flags(set_flags),
    .nzcv_in(nzcv_in), .cond(cond),
    .result(result), .wr_en(wr_en), .nzcv_out(nzcv_out), .cond_pass(cond_pass)
  );

  task automatic drive(input logic [4:0] o, input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] ac, input logic sc, input logic su,
                       input logic s, input logic [3:0] f, input logic [3:0] cc);
    op = o; rn = a; op2 = b; acc = ac; shift_c = sc; shift_used = su;
    set_flags = s; nzcv_in = f; cond = cc;
    #3;
  endtask

  task automatic chk(input string tag, input logic [31:0] er, input logic ew,
                     input logic [3:0] ef);
    total++;
    if (result !== er || wr_en !== ew || nzcv_out !== ef) begin
      bad++;
      $display("FAIL %s: got res=%h wr=%b f=%b, exp res=%h wr=%b f=%b",
               tag, result, wr_en, nzcv_out, er, ew, ef);
    end
  endtask

  task automatic chk_ctl(input string tag, input logic ew, input logic [3:0] ef);
    total++;
    if (wr_en !== ew || nzcv_out !== ef) begin
      bad++;
      $display("FAIL %s: got wr=%b f=%b, exp wr=%b f=%b", tag, wr_en, nzcv_out, ew, ef);
    end
  endtask

  // independent arithmetic model using wide signed/unsigned math
  task automatic arith_ref(input logic [4:0] o, input logic [31:0] a, input logic [31:0] b,
                           input logic [3:0] f, output logic [31:0] r, output logic [3:0] nf);
    longint ua, ub, cin, us, ss, sa, sb;
    logic c, v;
    ua = longint'(a); ub = longint'(b);
    sa = longint'($signed(a)); sb = longint'($signed(b));
    cin = longint'(f[1]);
    case (o)
      5'd4, 5'd11: begin us = ua + ub;           ss = sa + sb;           c = us > 64'hFFFFFFFF; end
      5'd5:        begin us = ua + ub + cin;     ss = sa + sb + cin;     c = us > 64'hFFFFFFFF; end
      5'd2, 5'd10: begin us = ua - ub;           ss = sa - sb;           c = ua >= ub; end
      5'd6:        begin us = ua - ub - (1-cin); ss = sa - sb - (1-cin); c = ua >= ub + (1-cin); end
      5'd3:        begin us = ub - ua;           ss = sb - sa;           c = ub >= ua; end
      default:     begin us = ub - ua - (1-cin); ss = sb - sa - (1-cin); c = ub >= ua + (1-cin); end
    endcase
    r = us[31:0];
    v = (ss > 64'sd2147483647) || (ss < -64'sd2147483648);
    nf = {r[31], r == 32'd0, c, v};
  endtask

  function automatic logic cond_ref(input logic [3:0] cc, input logic [3:0] f);
    logic n, z, c, v;
    {n, z, c, v} = f;
    case (cc)
      4'd0: return z;            4'd1: return !z;
      4'd2: return c;            4'd3: return !c;
      4'd4: return n;            4'd5: return !n;
      4'd6: return v;            4'd7: return !v;
      4'd8: return c && !z;      4'd9: return !c || z;
      4'd10: return n == v;      4'd11: return n != v;
      4'd12: return !z && (n == v);
      4'd13: return z || (n != v);
      4'd14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic t_idle;
    drive(5'd0, 32'h0, 32'h0, 32'h0, 0, 0, 0, 4'b0000, 4'd14);
    chk("R3 idle AND zero", 32'h0, 1'b1, 4'b0000);
  endtask

  task automatic t_arith;
    logic [31:0] r; logic [3:0] nf;
    logic [31:0] va [6] = '{32'h0, 32'h1, 32'h7FFFFFFF, 32'h80000000, 32'hFFFFFFFF, 32'h1234ABCD};
    logic [4:0]  ops [6] = '{5'd4, 5'd5, 5'd2, 5'd6, 5'd3, 5'd7};
    drive(5'd4, 32'h7FFFFFFF, 32'h1, 0, 0, 0, 1, 4'b0000, 4'd14);
    chk("R2 ADD signed overflow", 32'h80000000, 1'b1, 4'b1001);
    drive(5'd2, 32'd5, 32'd5, 0, 0, 0, 1, 4'b0000, 4'd14);
    chk("R2 SUB equal sets Z C", 32'h0, 1'b1, 4'b0110);
    drive(5'd2, 32'd3, 32'd5, 0, 0, 0, 1, 4'b0010, 4'd14);
    chk("R2 SUB borrow clears C", 32'hFFFFFFFE, 1'b1, 4'b1000);
    drive(5'd6, 32'd10, 32'd3, 0, 0, 0, 1, 4'b0000, 4'd14);
    chk("R1 SBC with C clear", 32'd6, 1'b1, 4'b0010);
    drive(5'd6, 32'h80000000, 32'h0, 0, 0, 0, 1, 4'b0000, 4'd14);
    chk("R2 SBC boundary overflow", 32'h7FFFFFFF, 1'b1, 4'b0011);
    drive(5'd7, 32'd1, 32'd9, 0, 0, 0, 1, 4'b0010, 4'd14);
    chk("R1 RSC with C set", 32'd8, 1'b1, 4'b0010);
    for (int i = 0; i < 6; i++)
      for (int j = 0; j < 6; j++)
        for (int k = 0; k < 6; k++)
          for (int fc = 0; fc < 2; fc++) begin
            arith_ref(ops[k], va[i], va[j], {2'b00, fc[0], 1'b0}, r, nf);
            drive(ops[k], va[i], va[j], 0, 0, 0, 1, {2'b00, fc[0], 1'b0}, 4'd14);
            chk($sformatf("R1 R2 op%0d a=%h b=%h", ops[k], va[i], va[j]), r, 1'b1, nf);
          end
  endtask

  task automatic t_logic;
    drive(5'd0, 32'hF0F0FFFF, 32'h0FF0F0F0, 0, 0, 0, 0, 4'b0000, 4'd14);
    chk("R3 AND", 32'h00F0F0F0, 1'b1, 4'b0000);
    drive(5'd1, 32'hAAAA5555, 32'hFFFF0000, 0, 0, 0, 0, 4'b0000, 4'd14);
    chk("R3 EOR", 32'h55555555, 1'b1, 4'b0000);
    drive(5'd12, 32'h00000F00, 32'h000000F0, 0, 0, 0, 0, 4'b0000, 4'd14);
    chk("R3 ORR", 32'h00000FF0, 1'b1, 4'b0000);
    drive(5'd14, 32'hFFFFFFFF, 32'h0000FFFF, 0, 0, 0, 0, 4'b0000, 4'd14);
    chk("R3 BIC", 32'hFFFF0000, 1'b1, 4'b0000);
    drive(5'd13, 32'h12345678, 32'hCAFE0001, 0, 0, 0, 0, 4'b0000, 4'd14);
    chk("R3 MOV", 32'hCAFE0001, 1'b1, 4'b0000);
    drive(5'd15, 32'h0, 32'h0, 0, 1, 1, 1, 4'b0001, 4'd14);
    chk("R4 MVN N set C from shifter V kept", 32'hFFFFFFFF, 1'b1, 4'b1011);
    drive(5'd13, 32'h0, 32'h0, 0, 0, 1, 1, 4'b1010, 4'd14);
    chk("R4 MOV zero C from shifter clear", 32'h0, 1'b1, 4'b0100);
    drive(5'd13, 32'h0, 32'h5, 0, 0, 0, 1, 4'b0011, 4'd14);
    chk("R4 MOV no shift keeps C and V", 32'h5, 1'b1, 4'b0011);
  endtask

  task automatic t_compare;
    drive(5'd10, 32'd7, 32'd7, 0, 0, 0, 0, 4'b1001, 4'd14);
    chk_ctl("R5 CMP equal without set_flags", 1'b0, 4'b0110);
    drive(5'd11, 32'hFFFFFFFF, 32'd1, 0, 0, 0, 0, 4'b0000, 4'd14);
    chk_ctl("R5 CMN carry out", 1'b0, 4'b0110);
    drive(5'd8, 32'hF0, 32'h0F, 0, 1, 1, 0, 4'b0001, 4'd14);
    chk_ctl("R5 TST zero, C shifter, V kept", 1'b0, 4'b0111);
    drive(5'd9, 32'h80000000, 32'h0, 0, 0, 0, 0, 4'b0010, 4'd14);
    chk_ctl("R5 TEQ negative keeps C", 1'b0, 4'b1010);
  endtask

  task automatic t_mult;
    drive(5'd16, 32'h00010000, 32'h00010000, 0, 0, 0, 1, 4'b0011, 4'd14);
    chk("R6 MUL low word zero", 32'h0, 1'b1, 4'b0111);
    drive(5'd17, 32'd3, 32'd4, 32'd5, 0, 0, 1, 4'b0000, 4'd14);
    chk("R6 MLA accumulate", 32'd17, 1'b1, 4'b0000);
    drive(5'd16, 32'hFFFFFFFF, 32'd2, 0, 0, 0, 1, 4'b0010, 4'd14);
    chk("R6 MUL negative", 32'hFFFFFFFE, 1'b1, 4'b1010);
  endtask

  task automatic t_noset;
    drive(5'd2, 32'd1, 32'd2, 0, 0, 0, 0, 4'b0101, 4'd14);
    chk("R7 SUB no set keeps flags", 32'hFFFFFFFF, 1'b1, 4'b0101);
    drive(5'd16, 32'd0, 32'd9, 0, 0, 0, 0, 4'b1000, 4'd14);
    chk("R7 MUL no set keeps flags", 32'd0, 1'b1, 4'b1000);
  endtask

  task automatic t_cond;
    for (int cc = 0; cc < 16; cc++)
      for (int f = 0; f < 16; f++) begin
        drive(5'd13, 32'h0, 32'h1, 0, 0, 0, 0, f[3:0], cc[3:0]);
        total++;
        if (cond_pass !== cond_ref(cc[3:0], f[3:0])) begin
          bad++;
          $display("FAIL R8 cond=%0d flags=%b: got %b exp %b",
                   cc, f[3:0], cond_pass, cond_ref(cc[3:0], f[3:0]));
        end
      end
  endtask

  task automatic t_fail;
    drive(5'd4, 32'd1, 32'd1, 0, 0, 0, 1, 4'b0000, 4'd0);
    chk_ctl("R9 EQ fails on ADD S", 1'b0, 4'b0000);
    drive(5'd10, 32'd1, 32'd1, 0, 0, 0, 1, 4'b1111, 4'd15);
    chk_ctl("R9 never code on CMP", 1'b0, 4'b1111);
  endtask

  task automatic t_undef;
    drive(5'd20, 32'd1, 32'd1, 0, 1, 1, 1, 4'b0110, 4'd14);
    chk_ctl("R10 opcode 20 inert", 1'b0, 4'b0110);
    drive(5'd31, 32'd0, 32'd0, 0, 0, 0, 1, 4'b1001, 4'd14);
    chk_ctl("R10 opcode 31 inert", 1'b0, 4'b1001);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_idle();
    t_arith();
    t_logic();
    t_compare();
    t_mult();
    t_noset();
    t_cond();
    t_fail();
    t_undef();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule